// File: doc/BRIEF.md
# Addressed-Write Four-Input Lookup Cell

This block is one logic cell of a reconfigurable fabric. It holds a sixteen-entry, one-bit-wide truth table and evaluates any Boolean function of four inputs by reading that table. In run mode the four logic inputs form the table index. The selected bit appears at once on a combinational output. The same bit is also captured into a flip-flop for a registered output.

To load a new function, a controller raises the write-mode control. It presents a four-bit entry index and one data bit, and each clock edge in write mode stores that bit into the indexed entry. Any entry can be written in any order. A full reload is sixteen write cycles, one per entry. While the cell is being loaded the registered output keeps its last value, so downstream logic sees a stable signal until run mode resumes.

Top module: `lut4_cfg_cell`

## Requirements
- R1: A synchronous reset (high at a clock edge) clears all sixteen table entries and the registered output to 0.
- R2: When cfg_wr is 1 at a clock edge, the entry whose index is the unsigned value of cfg_addr takes the value of cfg_bit. No other entry changes.
- R3: When cfg_wr is 0, comb_out equals the entry at the unsigned index lut_in, with lut_in[0] as the least significant bit, in the same cycle.
- R4: After a clock edge with cfg_wr at 0, reg_out equals the entry that lut_in addressed before that edge.
- R5: After a clock edge with cfg_wr at 1, reg_out keeps the value it had before that edge.
- R6: Sixteen consecutive write cycles covering indices 0 to 15 replace the whole function. The new function is visible at comb_out in the first run-mode cycle that follows.
- R7: While cfg_wr is 0, the values on cfg_addr and cfg_bit leave every table entry unchanged.
- R8: While cfg_wr is 1, lut_in does not choose the entry written. During that cycle comb_out shows the content of entry cfg_addr as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | 1 = write mode, 0 = run mode |
| cfg_addr | input | 4 | Table entry index used in write mode |
| cfg_bit | input | 1 | Data bit stored in write mode |
| lut_in | input | 4 | Logic inputs, used as the table index in run mode |
| comb_out | output | 1 | Combinational output: the addressed table bit |
| reg_out | output | 1 | Registered output |

## Verification
The assertions check four things on every cycle: the reset clear of the table, the addressed write landing in the right entry, the table staying unchanged in run mode, and the relation between reg_out and the previous cycle's read in both modes. Some behaviours can only be shown by the bench's scenarios. These are the index bit order, full reloads with several distinct functions followed by exhaustive reads, the read-before-write value on comb_out during loading, and lut_in having no effect on which entry is written.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
  localparam int LUTC_DEF_INPUTS = 4;

  typedef enum logic {
    LUTC_RUN = 1'b0,
    LUTC_CFG = 1'b1
  } lutc_mode_e;

  function automatic int lutc_entries(input int n_inputs);
    return 1 << n_inputs;
  endfunction
endpackage

// File: rtl/lutc_table.sv
module lutc_table #(
  parameter int ADDR_W = lutc_pkg::LUTC_DEF_INPUTS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_bit,
  output logic              rd_bit
);
  localparam int DEPTH = lutc_pkg::lutc_entries(ADDR_W);

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_bit;
    end
  end

  assign rd_bit = mem[addr];

  // R1
  table_clear_chk: assert property (@(posedge clk) $past(rst) |-> (mem == '0));

  // R2
  table_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mem[$past(addr)] == $past(wr_bit)));

  // R7
  table_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (mem == $past(mem)));
endmodule

// File: rtl/lutc_outreg.sv
module lutc_outreg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (load) begin
      q <= d;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (q == $past(q)));
endmodule

// File: rtl/lut4_cfg_cell.sv
module lut4_cfg_cell #(
  parameter int N_IN = lutc_pkg::LUTC_DEF_INPUTS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [N_IN-1:0] cfg_addr,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] lut_in,
  output logic            comb_out,
  output logic            reg_out
);
  import lutc_pkg::*;

  lutc_mode_e      mode;
  logic [N_IN-1:0] tbl_addr;
  logic            tbl_bit;

  assign mode     = lutc_mode_e'(cfg_wr);
  assign tbl_addr = (mode == LUTC_CFG) ? cfg_addr : lut_in;

  lutc_table #(.ADDR_W(N_IN)) u_table (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (mode == LUTC_CFG),
    .addr   (tbl_addr),
    .wr_bit (cfg_bit),
    .rd_bit (tbl_bit)
  );

  lutc_outreg u_oreg (
    .clk  (clk),
    .rst  (rst),
    .load (mode == LUTC_RUN),
    .d    (tbl_bit),
    .q    (reg_out)
  );

  assign comb_out = tbl_bit;

  // R4
  reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> (reg_out == $past(comb_out)));

  // R1
  reg_clear_chk: assert property (@(posedge clk) $past(rst) |-> !reg_out);
endmodule

// File: tb/lut4_cfg_cell_bench.sv
module lut4_cfg_cell_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic       cfg_bit = 1'b0;
  logic [3:0] lut_in = '0;
  logic       comb_out;
  logic       reg_out;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  logic model [16];
  logic reg_model;

  always #2 clk = ~clk;

  lut4_cfg_cell u_lut4_cfg_cell (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_bit(cfg_bit), .lut_in(lut_in), .comb_out(comb_out), .reg_out(reg_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: registered output compared one edge after each drive
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(reg_out, it.exp, it.tag);
    end
  end

  task automatic cyc(input logic wr, input logic [3:0] a, input logic b, input logic [3:0] li);
    logic e;
    @(negedge clk);
    cfg_wr = wr; cfg_addr = a; cfg_bit = b; lut_in = li;
    #1;
    if (wr) begin
      check(comb_out, model[a], "R8 old entry during write");
      sb_q.push_back('{reg_model, "R5 hold in write"});
      model[a] = b;
    end else begin
      check(comb_out, model[li], "R3 comb read");
      e = model[li];
      reg_model = e;
      sb_q.push_back('{e, "R4 registered read"});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 1'b0;
    reg_model = 1'b0;
    check(reg_out, 1'b0, "R1 reg_out after reset");
  endtask

  task automatic load_fn(input logic [15:0] fn, input logic [3:0] junk);
    for (int i = 0; i < 16; i++) cyc(1'b1, 4'(i), fn[i], junk ^ 4'(i));
  endtask

  task automatic read_all();
    for (int i = 0; i < 16; i++) cyc(1'b0, 4'hA, 1'b1, 4'(i));
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: table reads zero everywhere after reset
    read_all();
    // R6 and R8: AND function, lut_in driven with unrelated values while loading
    load_fn(16'h8000, 4'h5);
    read_all();
    // R6: XOR parity, loaded in reverse index order
    for (int i = 15; i >= 0; i--) cyc(1'b1, 4'(i), ^(4'(i)), 4'hF);
    read_all();
    // R3 bit order: only lut_in[0] set selects entry 1
    load_fn(16'h0002, 4'h0);
    cyc(1'b0, 4'h0, 1'b0, 4'h1);
    cyc(1'b0, 4'h0, 1'b0, 4'h8);
    // R7: cfg_addr/cfg_bit toggled in run mode, then table unchanged
    for (int i = 0; i < 16; i++) cyc(1'b0, 4'(i), ~model[i], 4'(15 - i));
    read_all();
    // R5: registered output held across a write burst after a 1 was read
    cyc(1'b0, 4'h0, 1'b0, 4'h1);
    cyc(1'b1, 4'h1, 1'b0, 4'h1);
    cyc(1'b1, 4'h2, 1'b1, 4'h1);
    cyc(1'b0, 4'h0, 1'b0, 4'h2);
    cyc(1'b0, 4'h0, 1'b0, 4'h1);
    // R2: single entry rewrite leaves others intact
    load_fn(16'h6996, 4'h3);
    cyc(1'b1, 4'h7, 1'b0, 4'h0);
    read_all();
    // R1: reset mid-operation clears a loaded table
    @(posedge clk); #1;
    do_reset();
    read_all();
    @(posedge clk); @(posedge clk); #2;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule